// File: doc/BRIEF.md
# Programmable Duty Clock Channel Divider

This block divides a stream of enabled input clock cycles into an output waveform with separately programmed low and high phase lengths. Division ratio and duty cycle are therefore both set by two small count fields, each holding the phase length minus one. A single clock edge drives all state. The `clk_en` input marks which cycles count as input clock cycles, and the configuration fields are treated as registered, quasi-static control.

A chip-level restart input (`sync_in`) realigns the channel. While it is asserted and not masked, the output sits at a selectable start level and the counters are cleared. After it is released, counting begins once a programmable number of enabled cycles has elapsed. Each channel can mask the restart. It can also be bypassed, in which case the enable stream is passed to the output. It can hold its output at a fixed level, or be powered down to a low output.

Top module: `chan_clk_divider`

## Requirements
- R1: After a restart with start level low and zero offset, the output stays low for exactly `low_cnt`+1 enabled cycles before going high.
- R2: The high phase lasts exactly `high_cnt`+1 enabled cycles. Low and high phases then alternate with lengths `low_cnt`+1 and `high_cnt`+1.
- R3: A cycle with `clk_en`=0 neither advances the phase counters nor changes the output level.
- R4: While `sync_in`=1 and `sync_ignore`=0, the output equals `start_hi` (1 = high phase first) and the counters are cleared. When `start_hi`=1 the first phase after release is the high phase.
- R5: After a restart, the first phase is lengthened by `phase_ofs` enabled cycles, because counting begins only after that many enabled cycles.
- R6: When `sync_ignore`=1, `sync_in` has no effect and the waveform continues unbroken.
- R7: When `force_hi`=1 the output is constant. It is 1 if `sync_ignore`=1 and 0 otherwise.
- R8: When `bypass`=1, the output equals the value `clk_en` had at the previous clock edge. The counters are frozen, and when bypass is cleared the waveform resumes where it stopped.
- R9: When `pwr_dn`=1 the output is 0, taking priority over bypass and force. After reset the output is 0.
- R10: A change of `low_cnt` or `high_cnt` takes effect only at the next phase boundary. A phase that is already running keeps the length latched at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Marks a counted input cycle |
| sync_in | input | 1 | Chip-level restart |
| low_cnt | input | CNT_W | Low phase length minus one |
| high_cnt | input | CNT_W | High phase length minus one |
| bypass | input | 1 | Pass enable stream to output, freeze counters |
| sync_ignore | input | 1 | Mask restart for this channel |
| force_hi | input | 1 | Hold output constant (high only with sync_ignore) |
| start_hi | input | 1 | Level of the first phase after restart |
| phase_ofs | input | OFS_W | Enabled cycles of delay before counting after restart |
| pwr_dn | input | 1 | Channel off, output low |
| div_out | output | 1 | Divided clock output |

## Verification
The bench uses the default widths, CNT_W=4 and OFS_W=4. This is small enough to sweep all 256 combinations of low and high counts, each with its own start level and phase offset. The expected waveform is computed from a closed-form position-modulo-period formula. Directed runs then cover a gapped enable, masked restarts during a live waveform, mid-phase count changes, freeze-and-resume through bypass, and the priority order among power-down, bypass and force.

// File: rtl/chdiv_pkg.sv
package chdiv_pkg;

  typedef enum logic [1:0] {
    SRC_OFF    = 2'd0,
    SRC_PASS   = 2'd1,
    SRC_FORCED = 2'd2,
    SRC_DIV    = 2'd3
  } out_src_e;

  // Priority: power-down, then bypass, then forced level, then divider.
  function automatic out_src_e pick_src(logic pwr, logic byp, logic frc);
    if (pwr)      return SRC_OFF;
    else if (byp) return SRC_PASS;
    else if (frc) return SRC_FORCED;
    else          return SRC_DIV;
  endfunction

  // Reload value for the phase that begins at the given level.
  function automatic logic [15:0] phase_limit(logic lvl, logic [15:0] lo, logic [15:0] hi);
    return lvl ? hi : lo;
  endfunction

endpackage

// File: rtl/chdiv_sync_qual.sv
module chdiv_sync_qual #(
  parameter int OFS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             sync_in,
  input  logic             sync_ignore,
  input  logic             hold,
  input  logic [OFS_W-1:0] phase_ofs,
  output logic             restart,
  output logic             advance
);

  logic [OFS_W-1:0] wait_q;
  logic             waiting;
  logic             tick;

  assign restart = sync_in & ~sync_ignore;
  assign waiting = (wait_q != '0);
  assign tick    = clk_en & ~hold & ~restart;
  assign advance = tick & ~waiting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                wait_q <= '0;
    else if (restart)          wait_q <= phase_ofs;
    else if (tick && waiting)  wait_q <= wait_q - 1'b1;
  end

  assert_offset_countdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && waiting) |=> (wait_q == $past(wait_q) - 1'b1));

  assert_no_advance_while_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !advance);

endmodule

// File: rtl/chdiv_phase_ctr.sv
module chdiv_phase_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             advance,
  input  logic             start_hi,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic [CNT_W-1:0] high_cnt,
  output logic             level,
  output logic             boundary
);
  import chdiv_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] start_lim;
  logic [CNT_W-1:0] next_lim;

  assign boundary  = advance & (cnt_q == lim_q);
  assign start_lim = CNT_W'(phase_limit(start_hi, 16'(low_cnt), 16'(high_cnt)));
  assign next_lim  = CNT_W'(phase_limit(~level,   16'(low_cnt), 16'(high_cnt)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= 1'b0;
      cnt_q <= '0;
      lim_q <= '1;
    end else if (restart) begin
      level <= start_hi;
      cnt_q <= '0;
      lim_q <= start_lim;
    end else if (boundary) begin
      level <= ~level;
      cnt_q <= '0;
      lim_q <= next_lim;
    end else if (advance) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_q);

  assert_flip_at_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !restart) |=> (level != $past(level)));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !advance) |=> ($stable(level) && $stable(cnt_q) && $stable(lim_q)));

  assert_restart_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (level == $past(start_hi) && cnt_q == '0));

  assert_limit_latched_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !boundary) |=> $stable(lim_q));

endmodule

// File: rtl/chdiv_out_sel.sv
module chdiv_out_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_en,
  input  logic pwr_dn,
  input  logic bypass,
  input  logic force_hi,
  input  logic sync_ignore,
  input  logic level,
  output logic div_out
);
  import chdiv_pkg::*;

  logic     pass_q;
  out_src_e src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pass_q <= 1'b0;
    else        pass_q <= clk_en;
  end

  assign src = pick_src(pwr_dn, bypass, force_hi);

  always_comb begin
    unique case (src)
      SRC_OFF:    div_out = 1'b0;
      SRC_PASS:   div_out = pass_q;
      SRC_FORCED: div_out = sync_ignore;
      default:    div_out = level;
    endcase
  end

  assert_pass_follows_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pwr_dn || !bypass || div_out == $past(clk_en)));

  assert_pwrdn_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> !div_out);

endmodule

// File: rtl/chan_clk_divider.sv
module chan_clk_divider #(
  parameter int CNT_W = 4,
  parameter int OFS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             sync_in,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic [CNT_W-1:0] high_cnt,
  input  logic             bypass,
  input  logic             sync_ignore,
  input  logic             force_hi,
  input  logic             start_hi,
  input  logic [OFS_W-1:0] phase_ofs,
  input  logic             pwr_dn,
  output logic             div_out
);

  logic restart;
  logic advance;
  logic level;
  logic boundary;

  chdiv_sync_qual #(.OFS_W(OFS_W)) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_en      (clk_en),
    .sync_in     (sync_in),
    .sync_ignore (sync_ignore),
    .hold        (bypass),
    .phase_ofs   (phase_ofs),
    .restart     (restart),
    .advance     (advance)
  );

  chdiv_phase_ctr #(.CNT_W(CNT_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .advance  (advance),
    .start_hi (start_hi),
    .low_cnt  (low_cnt),
    .high_cnt (high_cnt),
    .level    (level),
    .boundary (boundary)
  );

  chdiv_out_sel u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_en      (clk_en),
    .pwr_dn      (pwr_dn),
    .bypass      (bypass),
    .force_hi    (force_hi),
    .sync_ignore (sync_ignore),
    .level       (level),
    .div_out     (div_out)
  );

  assert_ignore_blocks_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ignore |-> !restart);

  assert_bypass_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> !boundary);

endmodule

// File: tb/chan_clk_divider_tb_top.sv
`timescale 1ns/100ps
module chan_clk_divider_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b0;
  logic       sync_in = 1'b0;
  logic [3:0] low_cnt = 4'd0;
  logic [3:0] high_cnt = 4'd0;
  logic       bypass = 1'b0;
  logic       sync_ignore = 1'b0;
  logic       force_hi = 1'b0;
  logic       start_hi = 1'b0;
  logic [3:0] phase_ofs = 4'd0;
  logic       pwr_dn = 1'b0;
  logic       div_out;

  int nvec = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  chan_clk_divider #(.CNT_W(4), .OFS_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sync_in(sync_in),
    .low_cnt(low_cnt), .high_cnt(high_cnt), .bypass(bypass),
    .sync_ignore(sync_ignore), .force_hi(force_hi), .start_hi(start_hi),
    .phase_ofs(phase_ofs), .pwr_dn(pwr_dn), .div_out(div_out)
  );

  // Expected level after j enabled edges following the restart edge.
  function automatic logic model(int j, int lo, int hi, logic st, int d);
    int p, a, b, q;
    p = j - d;
    if (p < 0) p = 0;
    a = st ? hi + 1 : lo + 1;
    b = st ? lo + 1 : hi + 1;
    q = p % (a + b);
    return (q < a) ? st : ~st;
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic got, logic exp);
    nvec++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: div_out=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic do_sync();
    sync_in = 1'b1;
    step();
    sync_in = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    nerr++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    int lo, hi, d, jj;
    logic st;
    // reset state (R9)
    step(); step();
    chk("R9 reset", div_out, 1'b0);
    rst_n = 1'b1;
    step();
    chk("R9 after reset", div_out, 1'b0);

    // R1 R2 R4 R5: sweep all low/high counts
    clk_en = 1'b1;
    for (int l = 0; l < 16; l++) begin
      for (int h = 0; h < 16; h++) begin
        st = 1'((l + h) & 1);
        d  = (l * 3 + h) % 16;
        low_cnt = 4'(l); high_cnt = 4'(h); start_hi = st; phase_ofs = 4'(d);
        do_sync();
        chk("R4 start level", div_out, st);
        for (int j = 1; j <= d + 2 * (l + h + 2); j++) begin
          step();
          chk(st ? "R2 R5 sweep" : "R1 R5 sweep", div_out, model(j, l, h, st, d));
        end
      end
    end

    // R4: held restart keeps start level
    low_cnt = 4'd1; high_cnt = 4'd1; phase_ofs = 4'd0; start_hi = 1'b1;
    sync_in = 1'b1;
    for (int k = 0; k < 6; k++) begin
      step();
      chk("R4 held sync", div_out, 1'b1);
    end
    sync_in = 1'b0;

    // R3: gapped enable
    lo = 2; hi = 1; d = 2; st = 1'b0;
    low_cnt = 4'(lo); high_cnt = 4'(hi); phase_ofs = 4'(d); start_hi = st;
    do_sync();
    jj = 0;
    for (int k = 0; k < 40; k++) begin
      clk_en = ((k % 3) != 1);
      step();
      if (clk_en) jj++;
      chk("R3 gapped enable", div_out, model(jj, lo, hi, st, d));
    end
    clk_en = 1'b1;

    // R6: masked restart does not disturb waveform
    lo = 2; hi = 2; d = 0; st = 1'b0;
    low_cnt = 4'(lo); high_cnt = 4'(hi); phase_ofs = 4'(d); start_hi = st;
    do_sync();
    sync_ignore = 1'b1;
    jj = 0;
    for (int k = 0; k < 20; k++) begin
      sync_in = (k == 4 || k == 5 || k == 11);
      step();
      jj++;
      chk("R6 sync ignored", div_out, model(jj, lo, hi, st, d));
    end
    sync_in = 1'b0;
    sync_ignore = 1'b0;

    // R10: count change mid-phase
    low_cnt = 4'd1; high_cnt = 4'd1; phase_ofs = 4'd0; start_hi = 1'b0;
    do_sync();
    step(); step();           // j=2, first high edge
    chk("R10 high begins", div_out, 1'b1);
    high_cnt = 4'd5;
    step(); chk("R10 old length kept", div_out, 1'b1);   // j=3
    step(); chk("R10 low after old high", div_out, 1'b0); // j=4
    step();                                                // j=5
    for (int j = 6; j <= 11; j++) begin
      step();
      chk("R10 new high length", div_out, 1'b1);
    end
    step(); chk("R10 low after new high", div_out, 1'b0); // j=12

    // R8: bypass passes enable and freezes counters
    lo = 3; hi = 3; d = 0; st = 1'b0;
    low_cnt = 4'(lo); high_cnt = 4'(hi); phase_ofs = 4'(d); start_hi = st;
    do_sync();
    step(); step();           // j=2
    bypass = 1'b1;
    for (int k = 0; k < 8; k++) begin
      clk_en = (k % 2 == 0);
      step();
      chk("R8 bypass pass", div_out, clk_en);
    end
    bypass = 1'b0;
    clk_en = 1'b1;
    for (int j = 3; j <= 14; j++) begin
      step();
      chk("R8 resume after bypass", div_out, model(j, lo, hi, st, d));
    end

    // R7: forced level
    force_hi = 1'b1; sync_ignore = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R7 force high", div_out, 1'b1);
    end
    sync_ignore = 1'b0;
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R7 force low without ignore", div_out, 1'b0);
    end

    // R9: power-down priority
    sync_ignore = 1'b1; force_hi = 1'b1; bypass = 1'b1; pwr_dn = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R9 pwr_dn over bypass/force", div_out, 1'b0);
    end
    bypass = 1'b0; force_hi = 1'b0;
    for (int k = 0; k < 6; k++) begin
      step();
      chk("R9 pwr_dn over divider", div_out, 1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule